// File: doc/BRIEF.md
# Windowed Hebbian Weight Updater

This block is the learning side of a single spiking neuron. Each time slice begins with a start pulse. When the slice is accepted, the block walks its local word store one address per cycle and presents each word to the neuron datapath. The store holds one signed weight for each of 30 presynaptic inputs, followed by two slope words. While a weight is presented, the block computes a replacement for it. The step is a reward if the matching presynaptic neuron's activity window is open and a decay if it is closed. The result is clamped to an asymmetric range. The replacement is stored only when the neuron fired in that slice.

The block also keeps its own activity window. The neuron's spike opens it, and it stays open for a fixed number of slices. Its flag is exported so that downstream neurons can use it as their presynaptic window input.

Two state machines set the behaviour. The window machine has the states WIN_IDLE and WIN_OPEN. It takes the transition open-on-spike from WIN_IDLE to WIN_OPEN. It takes restart-on-spike from WIN_OPEN to itself, which clears the slice count. It takes expire from WIN_OPEN to WIN_IDLE after the last slice of the window. The sweep machine has the states SW_IDLE, SW_WEIGHTS and SW_SLOPES. Its transitions are slice-accept (SW_IDLE to SW_WEIGHTS), weights-done (SW_WEIGHTS to SW_SLOPES) and sweep-done (SW_SLOPES to SW_IDLE).

Top module: `hebb_window_updater`

## Requirements
- R1: After reset, the window flag is 0 and the sweep-valid output is 0 with address 0. The first sweep shows every weight as 8 and the slope words as 3 (address 30) and 1 (address 31).
- R2: A start pulse is accepted only while no sweep runs. The sweep then presents addresses 0 to 31 on consecutive cycles, starting in the cycle after acceptance, with sweep-valid high for exactly those 32 cycles. A start pulse, with or without a spike, that arrives during a sweep has no effect.
- R3: An accepted start pulse with the spike input at 1 sets the window flag from the next cycle onward. The flag stays 1 for that slice and the following 15 slices, 16 in all, and then returns to 0.
- R4: A spike in an accepted slice while the window is already open restarts the count, so that the flag stays 1 for 16 slices counted from the new spike.
- R5: The candidate for synapse j, at address j, is the stored weight plus 2 when bit j of the presynaptic window input is 1. It is the stored weight minus 4 when that bit is 0. These steps come from a learning rate of 6 and a decay rate of 4.
- R6: Candidates are clamped to the range -32 to 127.
- R7: A candidate is stored only in a slice whose accepted start pulse carried a spike. A sweep presents the value held before that sweep, and an update becomes visible in the next sweep.
- R8: The slope words at addresses 30 and 31 are never written.
- R9: The presynaptic window flags are captured in the cycle the start pulse is accepted. Changes on that input during the sweep do not affect the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slice_go_i | input | 1 | Start pulse for a time slice |
| spike_i | input | 1 | Firing decision of the neuron for the slice, sampled with the start pulse |
| pre_win_i | input | 30 | Window flags of the presynaptic neurons, bit j for synapse j |
| win_flag_o | output | 1 | Own activity-window flag |
| sweep_valid_o | output | 1 | High while a sweep presents a word |
| sweep_addr_o | output | 5 | Address of the word being presented |
| sweep_word_o | output | 8 | Signed stored word at the presented address |

## Verification
Any corrupted internal state reaches the ports within one slice. A wrong candidate or a write at the wrong time shows up as a wrong weight at the same address one sweep later. A miscounted window shows up as a flag edge at the wrong slice boundary, visible in the first cycle of that slice. A sweep machine that loses its place breaks the address sequence or the 32-cycle valid span in the same sweep. A write that reaches a slope word changes the value read at address 30 or 31 in the following sweep.

// File: rtl/hebb_pkg.sv
package hebb_pkg;

    typedef enum logic [0:0] {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_e;

    typedef enum logic [1:0] {
        SW_IDLE    = 2'd0,
        SW_WEIGHTS = 2'd1,
        SW_SLOPES  = 2'd2
    } sweep_state_e;

endpackage

// File: rtl/hebb_window_fsm.sv
module hebb_window_fsm
    import hebb_pkg::*;
#(
    parameter int WIN_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slice_tick,
    input  logic fire,
    output logic win_flag
);
    localparam int CNT_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_SLICE = CNT_W'(WIN_LEN - 1);

    win_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state and count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WIN_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions: open-on-spike, restart-on-spike, expire
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (slice_tick) begin
            unique case (state_q)
                WIN_IDLE: begin
                    if (fire) begin
                        state_d = WIN_OPEN;
                        cnt_d   = '0;
                    end
                end
                WIN_OPEN: begin
                    if (fire) begin
                        cnt_d = '0;
                    end else if (cnt_q == LAST_SLICE) begin
                        state_d = WIN_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        win_flag = (state_q == WIN_OPEN);
    end

endmodule

// File: rtl/hebb_sweep_fsm.sv
module hebb_sweep_fsm
    import hebb_pkg::*;
#(
    parameter int N_SYN   = 30,
    parameter int N_SLOPE = 2
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       slice_go,
    input  logic                                       spike,
    input  logic [N_SYN-1:0]                           pre_win,
    output logic                                       slice_tick,
    output logic                                       sweep_valid,
    output logic                                       wr_en,
    output logic                                       pre_bit,
    output logic [$clog2(N_SYN+N_SLOPE)-1:0]           addr
);
    localparam int DEPTH  = N_SYN + N_SLOPE;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PAD    = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST_SYN  = ADDR_W'(N_SYN - 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    sweep_state_e      state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              fire_q;
    logic [N_SYN-1:0]  pre_snap_q;
    logic [PAD-1:0]    pre_pad;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: slice-accept, weights-done, sweep-done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_IDLE: begin
                if (slice_go) state_d = SW_WEIGHTS;
            end
            SW_WEIGHTS: begin
                if (addr_q == LAST_SYN) state_d = (N_SLOPE > 0) ? SW_SLOPES : SW_IDLE;
            end
            SW_SLOPES: begin
                if (addr_q == LAST_ADDR) state_d = SW_IDLE;
            end
            default: state_d = SW_IDLE;
        endcase
    end

    // address counter and per-slice captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            fire_q     <= 1'b0;
            pre_snap_q <= '0;
        end else if (state_q == SW_IDLE) begin
            addr_q <= '0;
            if (slice_go) begin
                fire_q     <= spike;
                pre_snap_q <= pre_win;
            end
        end else if (state_d == SW_IDLE) begin
            addr_q <= '0;
            fire_q <= 1'b0;
        end else begin
            addr_q <= addr_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        pre_pad     = PAD'(pre_snap_q);
        slice_tick  = (state_q == SW_IDLE) && slice_go;
        sweep_valid = (state_q != SW_IDLE);
        wr_en       = (state_q == SW_WEIGHTS) && fire_q;
        pre_bit     = (state_q == SW_WEIGHTS) && pre_pad[addr_q];
        addr        = addr_q;
    end

endmodule

// File: rtl/hebb_weight_calc.sv
module hebb_weight_calc #(
    parameter int W_BITS = 8,
    parameter int LEARN  = 6,
    parameter int DECAY  = 4,
    parameter int W_MIN  = -32,
    parameter int W_MAX  = 127
) (
    input  logic signed [W_BITS-1:0] cur_w,
    input  logic                     pre_act,
    output logic signed [W_BITS-1:0] new_w
);
    localparam int CW = W_BITS + 2;

    logic signed [CW-1:0] base;
    logic signed [CW-1:0] step;
    logic signed [CW-1:0] sum;

    always_comb begin
        base = CW'(cur_w);
        step = pre_act ? CW'(LEARN - DECAY) : CW'(-DECAY);
        sum  = base + step;
        if (sum > CW'(W_MAX)) begin
            new_w = W_BITS'(W_MAX);
        end else if (sum < CW'(W_MIN)) begin
            new_w = W_BITS'(W_MIN);
        end else begin
            new_w = W_BITS'(sum);
        end
    end

endmodule

// File: rtl/hebb_weight_store.sv
module hebb_weight_store #(
    parameter int N_SYN   = 30,
    parameter int N_SLOPE = 2,
    parameter int W_BITS  = 8,
    parameter int INIT_W  = 8,
    parameter int SLOPE_A = 3,
    parameter int SLOPE_B = 1
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [$clog2(N_SYN+N_SLOPE)-1:0]     addr,
    input  logic signed [W_BITS-1:0]             wr_data,
    output logic signed [W_BITS-1:0]             rd_data
);
    localparam int DEPTH  = N_SYN + N_SLOPE;
    localparam int ADDR_W = $clog2(DEPTH);

    logic signed [W_BITS-1:0] mem [DEPTH];

    function automatic logic signed [W_BITS-1:0] reset_word(input int idx);
        if (idx < N_SYN)       return W_BITS'(INIT_W);
        else if (idx == N_SYN) return W_BITS'(SLOPE_A);
        else                   return W_BITS'(SLOPE_B);
    endfunction

    // only synapse words carry a write path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= reset_word(i);
        end else if (wr_en) begin
            for (int i = 0; i < N_SYN; i++) begin
                if (addr == ADDR_W'(i)) mem[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (addr == ADDR_W'(i)) rd_data = mem[i];
        end
    end

endmodule

// File: rtl/hebb_window_updater.sv
module hebb_window_updater #(
    parameter int N_SYN   = 30,
    parameter int N_SLOPE = 2,
    parameter int W_BITS  = 8,
    parameter int WIN_LEN = 16,
    parameter int LEARN   = 6,
    parameter int DECAY   = 4,
    parameter int W_MIN   = -32,
    parameter int W_MAX   = 127,
    parameter int INIT_W  = 8,
    parameter int SLOPE_A = 3,
    parameter int SLOPE_B = 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               slice_go_i,
    input  logic                               spike_i,
    input  logic [N_SYN-1:0]                   pre_win_i,
    output logic                               win_flag_o,
    output logic                               sweep_valid_o,
    output logic [$clog2(N_SYN+N_SLOPE)-1:0]   sweep_addr_o,
    output logic signed [W_BITS-1:0]           sweep_word_o
);
    localparam int ADDR_W = $clog2(N_SYN + N_SLOPE);

    logic                     slice_tick;
    logic                     wr_en;
    logic                     pre_bit;
    logic [ADDR_W-1:0]        addr;
    logic signed [W_BITS-1:0] cur_w;
    logic signed [W_BITS-1:0] cand_w;

    hebb_sweep_fsm #(
        .N_SYN   (N_SYN),
        .N_SLOPE (N_SLOPE)
    ) sweep_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .slice_go    (slice_go_i),
        .spike       (spike_i),
        .pre_win     (pre_win_i),
        .slice_tick  (slice_tick),
        .sweep_valid (sweep_valid_o),
        .wr_en       (wr_en),
        .pre_bit     (pre_bit),
        .addr        (addr)
    );

    hebb_window_fsm #(
        .WIN_LEN (WIN_LEN)
    ) window_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .slice_tick (slice_tick),
        .fire       (spike_i),
        .win_flag   (win_flag_o)
    );

    hebb_weight_store #(
        .N_SYN   (N_SYN),
        .N_SLOPE (N_SLOPE),
        .W_BITS  (W_BITS),
        .INIT_W  (INIT_W),
        .SLOPE_A (SLOPE_A),
        .SLOPE_B (SLOPE_B)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (cand_w),
        .rd_data (cur_w)
    );

    hebb_weight_calc #(
        .W_BITS (W_BITS),
        .LEARN  (LEARN),
        .DECAY  (DECAY),
        .W_MIN  (W_MIN),
        .W_MAX  (W_MAX)
    ) calc_i (
        .cur_w   (cur_w),
        .pre_act (pre_bit),
        .new_w   (cand_w)
    );

    always_comb begin
        sweep_addr_o = addr;
        sweep_word_o = cur_w;
    end

endmodule

// File: rtl/hebb_window_updater_chk.sv
module hebb_window_updater_chk #(
    parameter int N_SYN   = 30,
    parameter int N_SLOPE = 2,
    parameter int W_BITS  = 8,
    parameter int WIN_LEN = 16,
    parameter int W_MIN   = -32,
    parameter int W_MAX   = 127,
    parameter int SLOPE_A = 3,
    parameter int SLOPE_B = 1
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               slice_go_i,
    input logic                               spike_i,
    input logic                               win_flag_o,
    input logic                               sweep_valid_o,
    input logic [$clog2(N_SYN+N_SLOPE)-1:0]   sweep_addr_o,
    input logic signed [W_BITS-1:0]           sweep_word_o
);
    localparam int DEPTH  = N_SYN + N_SLOPE;
    localparam int ADDR_W = $clog2(DEPTH);

    logic accepted;
    int   slices_open;

    assign accepted = slice_go_i && !sweep_valid_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slices_open <= 0;
        end else if (accepted) begin
            if (spike_i)              slices_open <= 0;
            else if (win_flag_o && slices_open < WIN_LEN) slices_open <= slices_open + 1;
        end
    end

    assert_sweep_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_valid_o && $past(sweep_valid_o)) |-> (sweep_addr_o == $past(sweep_addr_o) + 1'b1));

    assert_sweep_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_valid_o && sweep_addr_o == ADDR_W'(DEPTH - 1)) |=> !sweep_valid_o);

    assert_sweep_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sweep_valid_o) |-> (sweep_addr_o == '0));

    assert_win_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_flag_o) |-> $past(accepted && spike_i));

    assert_win_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(win_flag_o) |-> $past(accepted && !spike_i));

    assert_win_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        win_flag_o |-> (slices_open < WIN_LEN));

    assert_weight_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_valid_o && sweep_addr_o < ADDR_W'(N_SYN)) |->
        ((sweep_word_o >= W_BITS'(W_MIN)) && (sweep_word_o <= W_BITS'(W_MAX))));

    assert_slope_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_valid_o && sweep_addr_o >= ADDR_W'(N_SYN)) |->
        (sweep_word_o == ((sweep_addr_o == ADDR_W'(N_SYN)) ? W_BITS'(SLOPE_A) : W_BITS'(SLOPE_B))));

endmodule

bind hebb_window_updater hebb_window_updater_chk #(
    .N_SYN   (N_SYN),
    .N_SLOPE (N_SLOPE),
    .W_BITS  (W_BITS),
    .WIN_LEN (WIN_LEN),
    .W_MIN   (W_MIN),
    .W_MAX   (W_MAX),
    .SLOPE_A (SLOPE_A),
    .SLOPE_B (SLOPE_B)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .slice_go_i    (slice_go_i),
    .spike_i       (spike_i),
    .win_flag_o    (win_flag_o),
    .sweep_valid_o (sweep_valid_o),
    .sweep_addr_o  (sweep_addr_o),
    .sweep_word_o  (sweep_word_o)
);

// File: tb/hebb_window_updater_tb_top.sv
`timescale 1ns/1ps
module hebb_window_updater_tb_top;
    localparam int NS = 30;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              slice_go = 1'b0;
    logic              spike = 1'b0;
    logic [NS-1:0]     pre_win = '0;
    logic              win_flag;
    logic              sweep_valid;
    logic [4:0]        sweep_addr;
    logic signed [7:0] sweep_word;

    int total = 0;
    int bad = 0;
    int mw [NS];
    bit mrun = 1'b0;
    int mcnt = 0;

    always #2 clk = ~clk;

    hebb_window_updater dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .slice_go_i    (slice_go),
        .spike_i       (spike),
        .pre_win_i     (pre_win),
        .win_flag_o    (win_flag),
        .sweep_valid_o (sweep_valid),
        .sweep_addr_o  (sweep_addr),
        .sweep_word_o  (sweep_word)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one slice: start pulse, then 32 sweep cycles checked against the model
    task automatic run_slice(input bit spk, input logic [NS-1:0] pre, input bit disturb, input string req);
        int w;
        @(negedge clk);
        slice_go = 1'b1;
        spike    = spk;
        pre_win  = pre;
        if (spk) begin
            mrun = 1'b1;
            mcnt = 0;
        end else if (mrun) begin
            if (mcnt == 15) mrun = 1'b0;
            else mcnt++;
        end
        @(negedge clk);
        slice_go = 1'b0;
        spike    = 1'b0;
        check(win_flag == mrun, req, "window flag", int'(win_flag), int'(mrun));
        for (int k = 0; k < 32; k++) begin
            if (k > 0) @(negedge clk);
            check(sweep_valid === 1'b1, "R2", "sweep valid", int'(sweep_valid), 1);
            check(sweep_addr == 5'(k), "R2", "sweep address", int'(sweep_addr), k);
            w = sweep_word;
            if (k < NS)       check(w == mw[k], req, $sformatf("weight %0d", k), w, mw[k]);
            else if (k == NS) check(w == 3, "R8", "slope word 30", w, 3);
            else              check(w == 1, "R8", "slope word 31", w, 1);
            if (disturb && k == 10) begin
                slice_go = 1'b1;
                spike    = 1'b1;
                pre_win  = ~pre;
            end
            if (disturb && k == 11) begin
                slice_go = 1'b0;
                spike    = 1'b0;
            end
        end
        @(negedge clk);
        check(sweep_valid === 1'b0, "R2", "sweep ends after 32 cycles", int'(sweep_valid), 0);
        if (spk) begin
            for (int j = 0; j < NS; j++) begin
                mw[j] = mw[j] + (pre[j] ? 2 : -4);
                if (mw[j] > 127) mw[j] = 127;
                if (mw[j] < -32) mw[j] = -32;
            end
        end
    endtask

    task automatic t_reset();
        check(win_flag == 1'b0, "R1", "flag at reset", int'(win_flag), 0);
        check(sweep_valid == 1'b0, "R1", "valid at reset", int'(sweep_valid), 0);
        check(sweep_addr == 5'd0, "R1", "address at reset", int'(sweep_addr), 0);
        run_slice(1'b0, '0, 1'b0, "R1");
    endtask

    task automatic t_mixed();
        run_slice(1'b1, 30'h2AAA_AAAA, 1'b0, "R5");
        run_slice(1'b0, 30'h1555_5555, 1'b0, "R7");
        run_slice(1'b1, 30'h0000_FFFF, 1'b0, "R5");
        run_slice(1'b0, '0, 1'b0, "R7");
    endtask

    task automatic t_window_len();
        for (int s = 0; s < 16; s++) run_slice(1'b0, '0, 1'b0, "R3");
        run_slice(1'b1, '0, 1'b0, "R3");
        for (int s = 0; s < 18; s++) run_slice(1'b0, '0, 1'b0, "R3");
    endtask

    task automatic t_restart();
        run_slice(1'b1, '1, 1'b0, "R4");
        for (int s = 0; s < 9; s++) run_slice(1'b0, '0, 1'b0, "R4");
        run_slice(1'b1, '1, 1'b0, "R4");
        for (int s = 0; s < 17; s++) run_slice(1'b0, '0, 1'b0, "R4");
    endtask

    task automatic t_sat_high();
        for (int s = 0; s < 62; s++) run_slice(1'b1, '1, 1'b0, "R6");
        run_slice(1'b0, '0, 1'b0, "R6");
        check(mw[0] == 127, "R6", "model top clamp reached", mw[0], 127);
    endtask

    task automatic t_sat_low();
        for (int s = 0; s < 42; s++) run_slice(1'b1, '0, 1'b0, "R6");
        run_slice(1'b0, '0, 1'b0, "R6");
        check(mw[5] == -32, "R6", "model bottom clamp reached", mw[5], -32);
    endtask

    task automatic t_ignore();
        for (int s = 0; s < 17; s++) run_slice(1'b0, '0, 1'b0, "R2");
        run_slice(1'b0, 30'h0F0F_0F0F, 1'b1, "R2");
        run_slice(1'b0, '0, 1'b0, "R2");
    endtask

    task automatic t_snapshot();
        run_slice(1'b1, '1, 1'b1, "R9");
        run_slice(1'b0, '0, 1'b0, "R9");
        run_slice(1'b1, 30'h0000_0F0F, 1'b1, "R9");
        run_slice(1'b0, '0, 1'b0, "R9");
    endtask

    initial begin
        for (int j = 0; j < NS; j++) mw[j] = 8;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mixed();
        t_window_len();
        t_restart();
        t_sat_high();
        t_sat_low();
        t_ignore();
        t_snapshot();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule